// File: doc/BRIEF.md
# Quarter-Rate IQ Demodulator

This block turns a stream of signed samples of an intermediate-frequency signal into its in-phase and quadrature components. One analog path and one converter feed it, and the block does all of the I/Q separation in logic. The sample rate is exactly four times the IF, so every sample lands a quarter period after the previous one. Multiplying by the cosine and sine references therefore reduces to two steps: send the sample to either the I path or the Q path, then keep or negate it. No multiplier and no trigonometric table are needed.

Each path ends in its own boxcar low-pass filter. The filter spans a whole number of IF periods, and that number is a power of two. Its sum is shifted right, so the output has the same scale as the input. For an input `A·cos(ωt − φ)`, the outputs settle to `I = A·cos φ` and `Q = A·sin φ`.

A phase-alignment input re-synchronises the routing to a known sample and empties both filters. The output strobe stays low until a full window has been collected after the last reset.

Top module: `iq_demod4`

## Requirements
- R1: After `rst`, `outValid` is 0 and `outI` and `outQ` are 0.
- R2: A 2-bit phase counter advances on each accepted sample (`sampleValid` high, no reset) and sets its routing:
  - phase 0 adds +x to I;
  - phase 1 adds +x to Q;
  - phase 2 adds −x to I;
  - phase 3 adds −x to Q.
- R3: Each output is the sum of the last `2<<LOG2_PERIODS` contributions to its path, arithmetically shifted right by `LOG2_PERIODS+1` (rounding toward minus infinity). Slots not yet filled since reset count as zero.
- R4: Negating the most negative input gives the most positive value, not a wrapped value.
- R5: `outValid` is high for one cycle after each accepted phase-1 or phase-3 sample, and only once `4<<LOG2_PERIODS` samples have been accepted since the last reset.
- R6: `alignRst` sets the phase to 0, empties both filters, lowers `outValid` and sets both outputs to 0 on the next cycle. A sample presented in the same cycle is discarded.
- R7: A cycle with `sampleValid` low changes no state and leaves `outValid` low.
- R8: For an input that repeats the pattern (c, s, −c, −s), the outputs settle to `outI = c` and `outQ = s` once the window is full.
- R9: `outI` and `outQ` change only in cycles where a sample is accepted or a reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the IF |
| rst | input | 1 | Synchronous reset, active high |
| alignRst | input | 1 | Synchronous phase-alignment reset; sets the phase to 0 and empties the filters |
| sampleValid | input | 1 | `sampleIn` carries a sample this cycle |
| sampleIn | input | DW | Signed input sample |
| outI | output | DW | Signed filtered in-phase component |
| outQ | output | DW | Signed filtered quadrature component |
| outValid | output | 1 | One-cycle strobe: a fresh I/Q pair is available |

## Verification
The collision that matters here is an alignment reset arriving in the same cycle as a valid sample. The reset must win: the sample must reach neither filter nor the phase counter. The bench provokes this in the middle of a running stream by raising `alignRst` and `sampleValid` together. It checks that both outputs read zero on the next cycle. It then checks that the next `4<<LOG2_PERIODS` samples, counted from phase 0, produce exactly the strobes and values that an empty-filter model predicts. A single stray strobe, or a phase shifted by one, shows up in the scoreboard as an unexpected or mismatched item.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  typedef struct packed {
    logic clear;   // empty filters and restart the phase
    logic load;    // a sample is taken this cycle
    logic toQ;     // route to the quadrature path
    logic negate;  // use the negated sample
  } iqdStrobe_t;
endpackage

// File: rtl/iqd_ctrl.sv
module iqd_ctrl #(
  parameter int LOG2_PERIODS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alignRst,
  input  logic               sampleValid,
  output iqd_pkg::iqdStrobe_t strobe,
  output logic               outValid
);
  localparam int WIN = 4 << LOG2_PERIODS;
  localparam int FW  = $clog2(WIN + 1);

  logic [1:0]    phaseCnt;
  logic [FW-1:0] fillCnt;
  logic          windowDone;

  // The sample taken now completes the window.
  assign windowDone = (fillCnt >= FW'(WIN - 1));

  always_comb begin
    strobe.clear  = rst | alignRst;
    strobe.load   = sampleValid & ~(rst | alignRst);
    strobe.toQ    = phaseCnt[0];
    strobe.negate = phaseCnt[1];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      phaseCnt <= '0;
      fillCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.load & phaseCnt[0] & windowDone;
      if (strobe.load) begin
        phaseCnt <= phaseCnt + 2'd1;
        if (fillCnt != FW'(WIN)) fillCnt <= fillCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iqd_boxcar.sv
module iqd_boxcar #(
  parameter int DW           = 14,
  parameter int LOG2_PERIODS = 2
) (
  input  logic                 clk,
  input  logic                 clear,
  input  logic                 push,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] avg
);
  localparam int SHIFT = LOG2_PERIODS + 1;
  localparam int NPER  = 1 << SHIFT;
  localparam int SW    = DW + SHIFT;

  logic signed [DW-1:0] tap [NPER];
  logic signed [SW-1:0] runSum;
  logic signed [SW-1:0] scaled;
  logic signed [SW-1:0] dinExt;
  logic signed [SW-1:0] oldExt;

  assign dinExt = {{SHIFT{din[DW-1]}}, din};
  assign oldExt = {{SHIFT{tap[NPER-1][DW-1]}}, tap[NPER-1]};

  always_ff @(posedge clk) begin
    if (clear) begin
      for (int k = 0; k < NPER; k++) tap[k] <= '0;
      runSum <= '0;
    end else if (push) begin
      for (int k = NPER - 1; k > 0; k--) tap[k] <= tap[k-1];
      tap[0] <= din;
      runSum <= runSum + dinExt - oldExt;
    end
  end

  assign scaled = runSum >>> SHIFT;
  assign avg    = scaled[DW-1:0];
endmodule

// File: rtl/iqd_path.sv
module iqd_path #(
  parameter int DW           = 14,
  parameter int LOG2_PERIODS = 2
) (
  input  logic                 clk,
  input  iqd_pkg::iqdStrobe_t  strobe,
  input  logic signed [DW-1:0] sampleIn,
  output logic signed [DW-1:0] outI,
  output logic signed [DW-1:0] outQ
);
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  logic signed [DW-1:0] flipped;
  logic signed [DW-1:0] signedSample;
  logic signed [DW-1:0] pathAvg [2];

  // Negation saturates at the one value that has no positive twin.
  assign flipped      = (sampleIn == MINV) ? MAXV : -sampleIn;
  assign signedSample = strobe.negate ? flipped : sampleIn;

  for (genvar ch = 0; ch < 2; ch++) begin : g_path
    logic pushCh;
    assign pushCh = strobe.load & (strobe.toQ == (ch == 1));
    iqd_boxcar #(.DW(DW), .LOG2_PERIODS(LOG2_PERIODS)) u_box (
      .clk  (clk),
      .clear(strobe.clear),
      .push (pushCh),
      .din  (signedSample),
      .avg  (pathAvg[ch])
    );
  end

  assign outI = pathAvg[0];
  assign outQ = pathAvg[1];
endmodule

// File: rtl/iq_demod4.sv
module iq_demod4 #(
  parameter int DW           = 14,
  parameter int LOG2_PERIODS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alignRst,
  input  logic                 sampleValid,
  input  logic signed [DW-1:0] sampleIn,
  output logic signed [DW-1:0] outI,
  output logic signed [DW-1:0] outQ,
  output logic                 outValid
);
  iqd_pkg::iqdStrobe_t strobe;

  iqd_ctrl #(.LOG2_PERIODS(LOG2_PERIODS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .alignRst   (alignRst),
    .sampleValid(sampleValid),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  iqd_path #(.DW(DW), .LOG2_PERIODS(LOG2_PERIODS)) u_path (
    .clk     (clk),
    .strobe  (strobe),
    .sampleIn(sampleIn),
    .outI    (outI),
    .outQ    (outQ)
  );
endmodule

// File: rtl/iqd_checker.sv
module iqd_checker #(
  parameter int DW           = 14,
  parameter int LOG2_PERIODS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 alignRst,
  input logic                 sampleValid,
  input logic signed [DW-1:0] outI,
  input logic signed [DW-1:0] outQ,
  input logic                 outValid
);
  localparam int WIN = 4 << LOG2_PERIODS;
  localparam int CW  = $clog2(WIN + 1) + 1;

  logic [CW-1:0] seen;
  logic [1:0]    chkPhase;

  always_ff @(posedge clk) begin
    if (rst || alignRst) begin
      seen     <= '0;
      chkPhase <= '0;
    end else if (sampleValid) begin
      chkPhase <= chkPhase + 2'd1;
      if (seen < CW'(WIN)) seen <= seen + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!outValid && outI == '0 && outQ == '0));

  assert_strobe_on_odd_phase_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (chkPhase[0] == 1'b0));

  assert_window_filled_R5: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (seen >= CW'(WIN)));

  assert_align_clears_R6: assert property (@(posedge clk) disable iff (rst)
    alignRst |=> (!outValid && outI == '0 && outQ == '0));

  assert_idle_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (!sampleValid && !alignRst) |=> !outValid);

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!sampleValid && !alignRst) |=> ($stable(outI) && $stable(outQ)));
endmodule

bind iq_demod4 iqd_checker #(.DW(DW), .LOG2_PERIODS(LOG2_PERIODS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .alignRst   (alignRst),
  .sampleValid(sampleValid),
  .outI       (outI),
  .outQ       (outQ),
  .outValid   (outValid)
);

// File: tb/sim_iq_demod4.sv
`timescale 1ns/1ps
module sim_iq_demod4;
  localparam int DW    = 14;
  localparam int LP    = 2;
  localparam int SHIFT = LP + 1;
  localparam int NPER  = 1 << SHIFT;
  localparam int WIN   = 4 << LP;
  localparam int MINV  = -(1 << (DW - 1));
  localparam int MAXV  = (1 << (DW - 1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alignRst = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [DW-1:0] sampleIn = '0;
  logic signed [DW-1:0] outI, outQ;
  logic outValid;

  int checks = 0;
  int errors = 0;
  int hI [NPER];
  int hQ [NPER];
  int phase = 0;
  int fill = 0;
  int expI [$];
  int expQ [$];
  int lastI = 0;
  int lastQ = 0;
  int lcg = 12345;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  iq_demod4 #(.DW(DW), .LOG2_PERIODS(LP)) u0 (
    .clk(clk), .rst(rst), .alignRst(alignRst), .sampleValid(sampleValid),
    .sampleIn(sampleIn), .outI(outI), .outQ(outQ), .outValid(outValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int negSat(input int x);
    return (x == MINV) ? MAXV : -x;
  endfunction

  function automatic int sumOf(input int h [NPER]);
    int s = 0;
    for (int k = 0; k < NPER; k++) s += h[k];
    return s;
  endfunction

  task automatic modelClear();
    for (int k = 0; k < NPER; k++) begin hI[k] = 0; hQ[k] = 0; end
    phase = 0; fill = 0; lastI = 0; lastQ = 0;
  endtask

  // Driver: present one sample and push the expected result, if any.
  task automatic sendSample(input int x);
    int c;
    @(negedge clk);
    sampleIn = DW'(x);
    sampleValid = 1'b1;
    c = (phase >= 2) ? negSat(x) : x;  // R2 sign, R4 saturation
    if (phase % 2 == 0) begin
      for (int k = NPER - 1; k > 0; k--) hI[k] = hI[k-1];
      hI[0] = c;
    end else begin
      for (int k = NPER - 1; k > 0; k--) hQ[k] = hQ[k-1];
      hQ[0] = c;
    end
    fill++;
    lastI = sumOf(hI) >>> SHIFT;
    lastQ = sumOf(hQ) >>> SHIFT;
    if ((phase % 2 == 1) && fill >= WIN) begin
      expI.push_back(lastI);
      expQ.push_back(lastQ);
    end
    phase = (phase + 1) % 4;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sampleValid = 1'b0;
      sampleIn = DW'(7777);  // must be ignored (R7)
    end
  endtask

  task automatic doAlign(input bit withSample, input int x);
    @(negedge clk);
    alignRst = 1'b1;
    sampleValid = withSample;
    sampleIn = DW'(x);
    modelClear();
    @(negedge clk);
    alignRst = 1'b0;
    sampleValid = 1'b0;
  endtask

  // Monitor: compare every strobe against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (!rst && !finished && outValid) begin
      if (expI.size() == 0) begin
        chk("R5 unexpected strobe", 1, 0);
      end else begin
        chk("R3 outI", int'(outI), expI.pop_front());
        chk("R3 outQ", int'(outQ), expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 outI", int'(outI), 0);
    chk("R1 outQ", int'(outQ), 0);

    // R8 quarter-rate sinusoid, c = 1000, s = -600
    for (int n = 0; n < 3 * WIN; n++) begin
      case (n % 4)
        0: sendSample(1000);
        1: sendSample(-600);
        2: sendSample(-1000);
        default: sendSample(600);
      endcase
    end
    idle(1);
    chk("R8 outI", int'(outI), 1000);
    chk("R8 outQ", int'(outQ), -600);

    // R7/R9 idle cycles hold the outputs
    idle(4);
    chk("R9 outI hold", int'(outI), lastI);
    chk("R9 outQ hold", int'(outQ), lastQ);
    chk("R7 no strobe", int'(outValid), 0);

    // R3 pseudo-random stream with gaps, checks truncation rounding
    for (int n = 0; n < 5 * WIN; n++) begin
      lcg = lcg * 1103515245 + 12345;
      sendSample(((lcg >>> 8) % 8000));
      if (n % 7 == 3) idle(2);
    end
    idle(2);

    // R6 collision: align reset together with a valid sample
    doAlign(1'b1, 4000);
    chk("R6 outI cleared", int'(outI), 0);
    chk("R6 outQ cleared", int'(outQ), 0);
    chk("R6 outValid low", int'(outValid), 0);
    // R2 only phase-1 samples nonzero: I stays 0, Q fills
    for (int n = 0; n < WIN; n++) sendSample((n % 4 == 1) ? 800 : 0);
    idle(1);
    chk("R2 I path untouched", int'(outI), 0);
    chk("R2 Q path", int'(outQ), (800 * (NPER / 2)) >>> SHIFT);

    // R4 most negative value at phase 2 saturates
    doAlign(1'b0, 0);
    for (int n = 0; n < WIN; n++) sendSample((n % 4 == 2) ? MINV : 0);
    idle(1);
    chk("R4 saturated I", int'(outI), (MAXV * (NPER / 2)) >>> SHIFT);
    // R4 most negative at phase 0 stays negative
    doAlign(1'b0, 0);
    for (int n = 0; n < WIN; n++) sendSample((n % 4 == 0) ? MINV : 0);
    idle(1);
    chk("R4 unflipped I", int'(outI), (MINV * (NPER / 2)) >>> SHIFT);

    // R5 one short of a full window gives no strobe
    doAlign(1'b0, 0);
    for (int n = 0; n < WIN - 1; n++) sendSample(n * 13 - 100);
    idle(2);
    chk("R5 no early strobe", int'(outValid), 0);
    sendSample(55);
    idle(2);

    // R1 reset mid-stream
    @(negedge clk); rst = 1'b1; modelClear();
    @(negedge clk); rst = 1'b0;
    chk("R1 outI after reset", int'(outI), 0);
    chk("R1 outQ after reset", int'(outQ), 0);
    idle(2);
    chk("R5 queue drained", expI.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule